// File: doc/BRIEF.md
# 128-bit Xorshift-Rotate Random Word Generator

This block produces a stream of 64-bit pseudo-random words from 128 bits of internal state, kept as a low half and a high half. Each output word is the 64-bit sum of the two halves. The state then moves forward by a recurrence built from XOR, fixed rotations and one left shift. The period is 2^128 - 1 and the output is equidistributed in one dimension. The generator suits noise sources, Monte-Carlo stimulus and games. It is not suitable for cryptography.

After reset the state holds a built-in nonzero seed, so words are available at once. A single-cycle reseed strobe replaces the whole state with a 128-bit seed. An all-zero seed would lock the generator, so it is swapped for a second fixed nonzero pair. Each cycle with enable high yields one registered word one clock later, flagged by a valid pulse.

Top module: `xsr128_gen`

## Requirements
- R1: While reset (synchronous, active high) is asserted, outValid and outWord are 0. On release the state is lo = 64'h9E3779B97F4A7C15, hi = 64'hBF58476D1CE4E5B9.
- R2: At a rising edge with enable high and reseed low, outWord takes (lo + hi) mod 2^64 of the state before that edge, and outValid is 1 for the following cycle.
- R3: The same edge advances the state. With t = lo ^ hi, the new lo is rotl(lo,55) ^ t ^ (t << 14) and the new hi is rotl(t,36).
- R4: At an edge with enable and reseed both low, the state and outWord keep their values and outValid is 0 for the following cycle.
- R5: At an edge with reseed high, the state loads seedIn, with seedIn[63:0] going to lo and seedIn[127:64] going to hi.
- R6: An all-zero seedIn at reseed loads lo = 64'h94D049BB133111EB and hi = 64'h2545F4914F6CDD1D instead.
- R7: Reseed takes priority over enable. At that edge the state does not advance, outWord holds, and outValid is 0 for the following cycle.
- R8: Once out of reset the state is never all zero.
- R9: An unbroken run of 1000 enabled cycles yields exactly the words of the recurrence in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Produce one word and advance the state |
| reseed | input | 1 | Load the state from seedIn (wins over enable) |
| seedIn | input | 128 | New state: [63:0] low half, [127:64] high half |
| outValid | output | 1 | High for one cycle after each enabled edge |
| outWord | output | 64 | Registered sum of the two state halves |

## Verification
The hardest case to reach from the ports is the zero-seed substitution combined with reseed arriving while enable is high. Only one seed value out of 2^128 triggers the substitution, and random seeds never produce it. The stimulus therefore forces an all-zero seed in directed steps, and also in roughly a quarter of the random reseeds. Those reseeds are interleaved with random enable gaps, so the protection against lock-up, the priority rule and the hold behaviour are all followed by word-checked runs.

// File: rtl/xsr_pkg.sv
package xsr_pkg;

  // Strobes sent from the control to the datapath each cycle.
  typedef struct packed {
    logic init;   // force the built-in default state
    logic load;   // take the state from the seed input
    logic step;   // emit a word and advance the state
  } xsr_strobe_t;

endpackage

// File: rtl/xsr_adder.sv
// Chunked ripple adder. The carry passes from chunk to chunk; each chunk
// is a narrow add that the tools may map onto a fast carry chain.
module xsr_adder #(
  parameter int W     = 64,
  parameter int CHUNK = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sumOut
);
  localparam int NCH = W / CHUNK;

  logic [NCH:0] carry;
  assign carry[0] = 1'b0;

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    logic [CHUNK:0] part;
    assign part = {1'b0, opA[g*CHUNK +: CHUNK]}
                + {1'b0, opB[g*CHUNK +: CHUNK]}
                + {{CHUNK{1'b0}}, carry[g]};
    assign sumOut[g*CHUNK +: CHUNK] = part[CHUNK-1:0];
    assign carry[g+1] = part[CHUNK];
  end

  initial begin
    if (W % CHUNK != 0) $error("xsr_adder: W must be a multiple of CHUNK");
  end
endmodule

// File: rtl/xsr_ctrl.sv
// Control: decides each cycle between reset, reload and step, and
// registers the valid flag that accompanies every emitted word.
module xsr_ctrl
  import xsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        reseed,
  output xsr_strobe_t strb,
  output logic        outValid
);

  always_comb begin
    strb.init = rst;
    strb.load = !rst && reseed;
    strb.step = !rst && !reseed && enable;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= strb.step;
  end

  AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    (enable && !reseed) |=> outValid);                       // R2
  AST_RESEED_WINS: assert property (@(posedge clk) disable iff (rst)
    reseed |=> !outValid);                                   // R7
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    (!enable && !reseed) |=> !outValid);                     // R4
  AST_ONE_ACTION: assert property (@(posedge clk)
    $onehot0({strb.init, strb.load, strb.step}));            // R7
endmodule

// File: rtl/xsr_datapath.sv
// Datapath: both state halves, the seed check, the next-state function
// and the registered sum.
module xsr_datapath
  import xsr_pkg::*;
#(
  parameter int              W         = 64,
  parameter int              ROT_A     = 55,
  parameter int              SHL_B     = 14,
  parameter int              ROT_C     = 36,
  parameter int              ADD_CHUNK = 16,
  parameter logic [W-1:0]    DEF_LO    = 64'h9E3779B97F4A7C15,
  parameter logic [W-1:0]    DEF_HI    = 64'hBF58476D1CE4E5B9,
  parameter logic [W-1:0]    ALT_LO    = 64'h94D049BB133111EB,
  parameter logic [W-1:0]    ALT_HI    = 64'h2545F4914F6CDD1D
) (
  input  logic           clk,
  input  xsr_strobe_t    strb,
  input  logic [2*W-1:0] seedIn,
  output logic [W-1:0]   outWord
);

  logic [W-1:0] stLo, stHi;
  logic [W-1:0] nxtLo, nxtHi, mixT;
  logic [W-1:0] ldLo, ldHi;
  logic [W-1:0] sumW;
  logic         seedZero;

  // Seed selection: an all-zero seed would freeze the recurrence.
  assign seedZero = (seedIn == '0);
  assign ldLo     = seedZero ? ALT_LO : seedIn[W-1:0];
  assign ldHi     = seedZero ? ALT_HI : seedIn[2*W-1:W];

  // Next state from rotations, XOR and one shift.
  always_comb begin
    mixT  = stLo ^ stHi;
    nxtLo = ((stLo << ROT_A) | (stLo >> (W - ROT_A))) ^ mixT ^ (mixT << SHL_B);
    nxtHi = (mixT << ROT_C) | (mixT >> (W - ROT_C));
  end

  xsr_adder #(.W(W), .CHUNK(ADD_CHUNK)) u_add (
    .opA   (stLo),
    .opB   (stHi),
    .sumOut(sumW)
  );

  always_ff @(posedge clk) begin
    if (strb.init) begin
      stLo    <= DEF_LO;
      stHi    <= DEF_HI;
      outWord <= '0;
    end else if (strb.load) begin
      stLo    <= ldLo;
      stHi    <= ldHi;
    end else if (strb.step) begin
      stLo    <= nxtLo;
      stHi    <= nxtHi;
      outWord <= sumW;
    end
  end

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (strb.init)
    (stLo != '0) || (stHi != '0));                           // R8
  AST_WORD_IS_SUM: assert property (@(posedge clk) disable iff (strb.init)
    strb.step |=> (outWord == $past(stLo) + $past(stHi)));   // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (strb.init)
    (!strb.step && !strb.load) |=>
      ($stable(stLo) && $stable(stHi) && $stable(outWord))); // R4
  AST_ZERO_SEED_SWAP: assert property (@(posedge clk) disable iff (strb.init)
    (strb.load && seedIn == '0) |=>
      (stLo == ALT_LO && stHi == ALT_HI));                   // R6
  AST_LOAD_HOLDS_WORD: assert property (@(posedge clk) disable iff (strb.init)
    strb.load |=> $stable(outWord));                         // R7
endmodule

// File: rtl/xsr128_gen.sv
// Thin top: control plus datapath.
module xsr128_gen
  import xsr_pkg::*;
#(
  parameter int WORD_W    = 64,
  parameter int ADD_CHUNK = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                reseed,
  input  logic [2*WORD_W-1:0] seedIn,
  output logic                outValid,
  output logic [WORD_W-1:0]   outWord
);

  xsr_strobe_t strb;

  xsr_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .reseed  (reseed),
    .strb    (strb),
    .outValid(outValid)
  );

  xsr_datapath #(.W(WORD_W), .ADD_CHUNK(ADD_CHUNK)) u_dp (
    .clk    (clk),
    .strb   (strb),
    .seedIn (seedIn),
    .outWord(outWord)
  );
endmodule

// File: tb/sim_xsr128_gen.sv
module sim_xsr128_gen;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enable = 1'b0;
  logic         reseed = 1'b0;
  logic [127:0] seedIn = '0;
  logic         outValid;
  logic [63:0]  outWord;

  int checks = 0;
  int fails  = 0;

  logic [63:0] mLo, mHi, expWord;
  logic        expValid;

  localparam logic [63:0] D_LO = 64'h9E3779B97F4A7C15;
  localparam logic [63:0] D_HI = 64'hBF58476D1CE4E5B9;
  localparam logic [63:0] A_LO = 64'h94D049BB133111EB;
  localparam logic [63:0] A_HI = 64'h2545F4914F6CDD1D;

  always #10 clk = ~clk;   // 50 MHz

  xsr128_gen u0 (
    .clk(clk), .rst(rst), .enable(enable), .reseed(reseed),
    .seedIn(seedIn), .outValid(outValid), .outWord(outWord)
  );

  function automatic logic [63:0] rotl64(input logic [63:0] x, input int k);
    return (x << k) | (x >> (64 - k));
  endfunction

  task automatic modelStep();
    logic [63:0] t;
    t   = mLo ^ mHi;
    mLo = rotl64(mLo, 55) ^ t ^ (t << 14);
    mHi = rotl64(t, 36);
  endtask

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at a falling edge, predict, check at the next falling edge.
  task automatic cycle(input logic en, input logic rs, input logic [127:0] sd,
                       input string tag);
    enable = en; reseed = rs; seedIn = sd;
    if (rs) begin
      if (sd == '0) begin mLo = A_LO; mHi = A_HI; end
      else begin mLo = sd[63:0]; mHi = sd[127:64]; end
      expValid = 1'b0;
    end else if (en) begin
      expWord  = mLo + mHi;
      expValid = 1'b1;
      modelStep();
    end else begin
      expValid = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, {63'd0, outValid}, {63'd0, expValid});
    check({tag, " word"}, outWord, expWord);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mLo = D_LO; mHi = D_HI; expWord = '0; expValid = 1'b0;
    enable = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports, even with enable high
    check("R1 reset valid", {63'd0, outValid}, 64'd0);
    check("R1 reset word", outWord, 64'd0);
    rst = 1'b0;

    // R1, R2, R3: first words from the default seed
    cycle(1'b1, 1'b0, '0, "R1 first word");
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, '0, "R3 step");

    // R4: idle cycles hold word and state
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, '0, "R4 idle");
    cycle(1'b1, 1'b0, '0, "R4 resume");

    // R5: explicit seed, halves placed by bit position
    cycle(1'b0, 1'b1, {64'h0000000000000002, 64'h0000000000000001}, "R5 reseed");
    cycle(1'b1, 1'b0, '0, "R5 first word");
    cycle(1'b1, 1'b0, '0, "R5 second word");

    // R6: all-zero seed is replaced
    cycle(1'b0, 1'b1, '0, "R6 zero seed");
    cycle(1'b1, 1'b0, '0, "R6 first word");

    // R7: reseed together with enable
    cycle(1'b1, 1'b1, {64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000}, "R7 priority");
    cycle(1'b1, 1'b0, '0, "R7 after");
    cycle(1'b1, 1'b1, '0, "R7 zero priority");
    cycle(1'b1, 1'b0, '0, "R7 zero after");

    // R9: 1000 unbroken enabled words from a random seed
    cycle(1'b0, 1'b1, {$urandom, $urandom, $urandom, $urandom}, "R9 seed");
    for (int i = 0; i < 1000; i++) cycle(1'b1, 1'b0, '0, "R9 run");

    // R8 and mixed traffic: random gaps, reseeds, some zero seeds
    for (int i = 0; i < 3000; i++) begin
      logic en, rs;
      logic [127:0] sd;
      en = ($urandom % 4) != 0;
      rs = ($urandom % 40) == 0;
      sd = (($urandom % 4) == 0) ? 128'd0 : {$urandom, $urandom, $urandom, $urandom};
      cycle(en, rs, sd, "R8 mixed");
    end

    // R1 again: mid-run reset restores the default seed
    rst = 1'b1; enable = 1'b0; reseed = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 re-reset valid", {63'd0, outValid}, 64'd0);
    check("R1 re-reset word", outWord, 64'd0);
    rst = 1'b0; mLo = D_LO; mHi = D_HI;
    cycle(1'b1, 1'b0, '0, "R1 default again");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule